// File: doc/BRIEF.md
# SD Four-Lane Block Data Receiver

This block takes in one data block from the four SD data lines. A host arms it with a one-cycle start request. It then watches the lines on every cycle where the data clock-enable is high. When all four lines read low together, that nibble is the start marker. The block then pairs up the following nibbles into bytes and hands each byte to a receive FIFO through a single-cycle push.

Each line carries its own serial CRC16 after the data bits. The block computes the expected CRC for each line while the data arrives. It compares the expected values with the received CRC bits and checks that the end marker is all ones. It then gives a one-cycle done pulse with a pass/fail flag. Each new block starts from cleared counters, so blocks can follow one another in any order and stay aligned.

Top module: `sd_blk_rx`

## Requirements
- R1: During reset and in the first cycle after it, `push`, `done` and `crc_err` are 0.
- R2: The receiver ignores the data lines until `start` has been high on a clock edge. Data lines held at 0 while the receiver is not armed produce no push and no done.
- R3: Once armed, a block begins only on a sampled nibble equal to 4'h0, meaning all four lines are low. Any other value, including values with only some lines low, is ignored.
- R4: The data lines are sampled only on edges where `dat_en` is 1. Values present while `dat_en` is 0 have no effect on any output.
- R5: Within each byte, the first nibble received after the start marker goes to bits 7:4 and the second nibble goes to bits 3:0. A byte sent as 0x12 is pushed as 0x12.
- R6: Each block produces exactly BLK_BYTES pushes (512 by default), in arrival order. `push` is high for the one cycle that follows the edge sampling the second nibble of a byte. `push` and `done` are never high together.
- R7: For each line `i` (the line driven as `dat[i]`), the block computes a CRC16 over that line's data bits. The CRC uses x^16+x^12+x^5+1, starts from zero, and the received CRC is sent most significant bit first. A mismatch on any line sets `crc_err` with `done`.
- R8: The nibble sampled after the 16 CRC bits is the end marker. Any value other than 4'hF sets `crc_err` with `done`.
- R9: `done` is high for exactly one cycle per block, in the cycle after the end marker is sampled. `crc_err` is valid in that cycle and is 0 in every other cycle.
- R10: Byte, nibble, CRC-bit and error state are cleared at the start of each block. A block received right after another block, including a failed one, is pushed and checked correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm request for one block |
| dat_en | input | 1 | Sample qualifier for the data lines |
| dat | input | 4 | SD data lines, line i on bit i |
| push | output | 1 | Byte push strobe to the receive FIFO |
| push_data | output | 8 | Assembled byte |
| done | output | 1 | One-cycle end-of-block pulse |
| crc_err | output | 1 | CRC or end-marker failure, valid with done |

## Verification
Blocks are sent with three data patterns:
- An incrementing byte ramp shows whether the nibble order within each byte is right.
- A scrambled sequence mixes high and low nibbles, so a slipped nibble shows up as changed bytes.
- A constant 0x12 fill shows whether the two halves of a byte are swapped.

One run inserts an idle cycle after every nibble and drives inverted junk while `dat_en` is low. This separates real samples from ignored cycles, including a junk 4'h0 before the start marker. Each block is preceded by partial-low nibbles to check that they do not start a block. Further blocks are sent with a single corrupted CRC bit on one line and with a wrong end marker, to check that each sets the error flag. These are sent back to back with good blocks to check that no state carries over from one block to the next.

// File: rtl/sd_blk_rx.sv
module sd_blk_rx #(
  parameter int BLK_BYTES = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dat_en,
  input  logic [3:0] dat,
  output logic       push,
  output logic [7:0] push_data,
  output logic       done,
  output logic       crc_err
);
  localparam int BW = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam logic [BW-1:0] LAST = BW'(BLK_BYTES - 1);
  localparam logic [15:0] POLY = 16'h1021;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_DATA, S_CRC, S_END} st_t;

  st_t              st;
  logic [BW-1:0]    bcnt;
  logic             half;
  logic [3:0]       hi;
  logic [3:0]       ccnt;
  logic             mism;
  logic [3:0][15:0] crc, crc_nxt, crc_sh;
  logic [3:0]       crc_msb;

  for (genvar g = 0; g < 4; g++) begin : g_lane
    assign crc_sh[g]  = {crc[g][14:0], 1'b0};
    assign crc_nxt[g] = crc_sh[g] ^ ({16{crc[g][15] ^ dat[g]}} & POLY);
    assign crc_msb[g] = crc[g][15];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      bcnt <= '0;
      half <= 1'b0;
      hi <= '0;
      ccnt <= '0;
      mism <= 1'b0;
      crc <= '0;
      push <= 1'b0;
      push_data <= '0;
      done <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      push <= 1'b0;
      done <= 1'b0;
      crc_err <= 1'b0;
      unique case (st)
        S_IDLE: if (start) st <= S_ARM;
        S_ARM: if (dat_en && dat == 4'h0) begin
          st <= S_DATA;
          bcnt <= '0;
          half <= 1'b0;
          ccnt <= '0;
          mism <= 1'b0;
          crc <= '0;
        end
        S_DATA: if (dat_en) begin
          crc <= crc_nxt;
          if (!half) begin
            hi <= dat;
            half <= 1'b1;
          end else begin
            push <= 1'b1;
            push_data <= {hi, dat};
            half <= 1'b0;
            if (bcnt == LAST) st <= S_CRC;
            else bcnt <= bcnt + 1'b1;
          end
        end
        S_CRC: if (dat_en) begin
          if (dat != crc_msb) mism <= 1'b1;
          crc <= crc_sh;
          ccnt <= ccnt + 1'b1;
          if (ccnt == 4'd15) st <= S_END;
        end
        S_END: if (dat_en) begin
          done <= 1'b1;
          crc_err <= mism | (dat != 4'hF);
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_push_from_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> $past(st == S_DATA));
  assert_push_done_apart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && done));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(st == S_END));
  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> done);
endmodule

// File: tb/tb_sd_blk_rx.sv
`timescale 1ns/1ps
module tb_sd_blk_rx;
  localparam int NB = 512;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dat_en = 1'b0;
  logic [3:0] dat = 4'hF;
  logic push, done, crc_err;
  logic [7:0] push_data;

  int checks = 0, failures = 0;
  int npush = 0, ndone = 0, stray = 0;
  logic last_err = 1'b0;
  logic [7:0] got [NB + 8];
  logic [7:0] exp_mem [NB];

  always #2.5 clk = ~clk;

  sd_blk_rx #(.BLK_BYTES(NB)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dat_en(dat_en), .dat(dat),
    .push(push), .push_data(push_data), .done(done), .crc_err(crc_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (push) begin
      if (npush < NB + 8) got[npush] = push_data;
      npush++;
    end
    if (done) begin
      ndone++;
      last_err = crc_err;
    end
    if (crc_err && !done) stray++;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic [15:0] crc_step(input [15:0] c, input bit b);
    crc_step = (c[15] ^ b) ? ({c[14:0], 1'b0} ^ 16'h1021) : {c[14:0], 1'b0};
  endfunction

  function automatic [7:0] pat_byte(input int p, input int i);
    case (p)
      0: pat_byte = i[7:0];
      1: pat_byte = 8'((i * 37 + 11) ^ 8'h5A);
      default: pat_byte = 8'h12;
    endcase
  endfunction

  task automatic nib(input [3:0] v, input bit gap);
    @(negedge clk); dat = v; dat_en = 1'b1;
    if (gap) begin @(negedge clk); dat_en = 1'b0; dat = ~v; end
  endtask

  task automatic send_block(input int p, input bit gap, input int bad_lane, input [3:0] endn);
    logic [15:0] lc [4];
    for (int g = 0; g < 4; g++) lc[g] = '0;
    for (int i = 0; i < NB; i++) begin
      exp_mem[i] = pat_byte(p, i);
      for (int g = 0; g < 4; g++) begin
        lc[g] = crc_step(lc[g], exp_mem[i][4 + g]);
        lc[g] = crc_step(lc[g], exp_mem[i][g]);
      end
    end
    if (bad_lane >= 0) lc[bad_lane][0] = ~lc[bad_lane][0];
    npush = 0; ndone = 0; stray = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    nib(4'hF, gap); nib(4'hE, gap); nib(4'h1, gap); nib(4'h8, gap);
    nib(4'h0, gap);
    for (int i = 0; i < NB; i++) begin
      nib(exp_mem[i][7:4], gap);
      nib(exp_mem[i][3:0], gap);
    end
    for (int b = 15; b >= 0; b--) nib({lc[3][b], lc[2][b], lc[1][b], lc[0][b]}, gap);
    nib(endn, gap);
    @(negedge clk); dat_en = 1'b0; dat = 4'hF;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_block(input string tag, input bit exp_err);
    int bad = 0, first = -1;
    chk(npush == NB, {"R6 push count ", tag}, npush, NB);
    for (int i = 0; i < NB; i++)
      if (got[i] !== exp_mem[i]) begin bad++; if (first < 0) first = i; end
    chk(bad == 0, {"R5 byte data ", tag}, (first < 0) ? 0 : int'(got[first]),
        (first < 0) ? 0 : int'(exp_mem[first]));
    chk(ndone == 1, {"R9 done pulses ", tag}, ndone, 1);
    chk(last_err == exp_err, {"R7/R8 crc_err ", tag}, last_err, exp_err);
    chk(stray == 0, {"R9 crc_err outside done ", tag}, stray, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(push === 1'b0 && done === 1'b0 && crc_err === 1'b0, "R1 reset outputs",
        {push, done, crc_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(push === 1'b0 && done === 1'b0 && crc_err === 1'b0, "R1 after release",
        {push, done, crc_err}, 0);
  endtask

  task automatic t_unarmed;
    npush = 0; ndone = 0;
    @(negedge clk); dat = 4'h0; dat_en = 1'b1;
    repeat (40) @(negedge clk);
    dat = 4'hF; dat_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(npush == 0, "R2 no push unarmed", npush, 0);
    chk(ndone == 0, "R2 no done unarmed", ndone, 0);
  endtask

  task automatic t_ramp;
    send_block(0, 1'b0, -1, 4'hF);
    check_block("ramp", 1'b0);
    chk(got[18] == 8'h12, "R5 nibble order 0x12", got[18], 8'h12);
  endtask

  task automatic t_gapped;
    send_block(1, 1'b1, -1, 4'hF);
    check_block("gapped R4 R3", 1'b0);
  endtask

  task automatic t_bad_crc;
    send_block(1, 1'b0, 2, 4'hF);
    check_block("bad crc lane2 R7", 1'b1);
  endtask

  task automatic t_bad_end;
    send_block(0, 1'b0, -1, 4'hE);
    check_block("bad end R8", 1'b1);
  endtask

  task automatic t_back_to_back;
    send_block(2, 1'b0, 0, 4'hF);
    check_block("b2b first R10", 1'b1);
    chk(got[0] == 8'h12, "R5 fill 0x12", got[0], 8'h12);
    send_block(0, 1'b0, -1, 4'hF);
    check_block("b2b second R10", 1'b0);
    send_block(1, 1'b1, -1, 4'hF);
    check_block("b2b third R10", 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_unarmed();
    t_ramp();
    t_gapped();
    t_bad_crc();
    t_bad_end();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule